// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four shared, level-sensitive PCI interrupt request lines onto sixteen inputs of a legacy interrupt controller. Each request line has one byte-wide routing register, written and read over a small byte-addressed configuration port. The register holds the number of the controller input that the line drives. A value of 16 or above parks the line, so it drives nothing.

The block keeps a registered level matrix with one bit per (output, line) pair. The bit at index `output*4 + line` is set while that line is high and is steered to that output. Each controller input is the OR of its four matrix bits. The matrix is recomputed on every clock from the live request levels and the routing values, including a value being written in that cycle. A rewrite of the routing therefore rebuilds the whole matrix at the same edge that stores the new byte.

Two side helpers round the block out. A swizzle maps a device number and an INTx pin to the request line that the pin lands on. A route query reports, for a given pin index, whether its line is live and which controller input it reaches.

Top module: `pirq_steer`

## Requirements
- R1: After reset, all four routing registers read 0x80, `irq_out` is all zero, and a query of any pin reports disabled.
- R2: A write at offset 0x60+i stores the byte for line i, where i is 0 to 3 for lines A to D. A read presents the address, and `cfg_rdata` shows the stored byte one clock later. A read of any other offset returns 0x00.
- R3: A write to any offset outside 0x60..0x63 changes no routing register and no output.
- R4: When line p is high and its routing value r is below 16, `irq_out[r]` is high one clock after the input is sampled. A line drives at most one output.
- R5: A routing value of 16 or more, such as 0x10, 0x80 or 0xFF, disables the line. Its input level then has no effect on any output.
- R6: `irq_out[o]` is the OR of all enabled lines steered to o, so lines that share an output merge.
- R7: A routing write takes effect at the edge that stores it. The old target drops and the new target rises in the same clock, while the line stays high.
- R8: A query presents `qry_pin`. One clock later, `qry_en`=1 and `qry_num` equal to the stored value if that value is below 16. Otherwise `qry_en`=0 and `qry_num`=5'h1F.
- R9: The swizzle gives `swz_line` = (`swz_pin` + `swz_dev` − 1) mod 4, one clock after its inputs are sampled. Pin codes 0..3 stand for INTA..INTD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data |
| line_in | input | 4 | Request line levels A..D, active high |
| irq_out | output | 16 | Interrupt controller input levels |
| qry_pin | input | 2 | Pin index to query |
| qry_en | output | 1 | Queried pin is routed |
| qry_num | output | 5 | Queried target, 5'h1F when disabled |
| swz_dev | input | 5 | Device number for the swizzle |
| swz_pin | input | 2 | INTx pin code for the swizzle |
| swz_line | output | 2 | Request line the pin lands on |

## Verification
A stale or mis-indexed bit in the level matrix shows up at `irq_out` one clock after the request pattern or the routing that exposes it. Such a bit either lights an output that no live line targets or fails to drop an old target after a rewrite. The bench sweeps all sixteen request patterns under many routing sets, including shared, boundary (15, 16) and disabled values, so a wrong bit appears within a single pattern step. A fault in the register file appears on the next readback or query, one clock after the address is presented.

// File: rtl/pirq_steer_pkg.sv
package pirq_steer_pkg;
  localparam int ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_steer_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  parameter route_t RESET_VAL = 8'h80
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic [ADDR_W-1:0] addr,
  input  route_t wdata,
  output logic [NUM_LINES-1:0][ROUTE_W-1:0] route_q,
  output logic [NUM_LINES-1:0][ROUTE_W-1:0] route_nx,
  output route_t rdata
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_LINES);

  logic [ADDR_W-1:0] offs;
  logic in_rng;

  assign offs = addr - BASE;
  assign in_rng = (addr >= BASE) && (offs < SPAN);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_reg
    logic hit;
    assign hit = we && (addr == BASE + ADDR_W'(i));
    assign route_nx[i] = hit ? wdata : route_q[i];

    always_ff @(posedge clk) begin
      if (rst) route_q[i] <= RESET_VAL;
      else     route_q[i] <= route_nx[i];
    end

    // R2: a write to this line's offset lands in its register
    assert_route_store_R2: assert property (@(posedge clk) disable iff (rst)
      (we && addr == BASE + ADDR_W'(i)) |=> (route_q[i] == $past(wdata)));
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (in_rng) rdata <= route_q[offs[IDX_W-1:0]];
    else             rdata <= '0;
  end

  // R3: writes outside the window leave every register alone
  assert_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
    (we && !in_rng) |=> $stable(route_q));
endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix
  import pirq_steer_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes,
  output logic [NUM_OUTS-1:0] irq_out
);
  localparam int VEC_W = NUM_LINES * NUM_OUTS;
  localparam int OUT_W = $clog2(NUM_OUTS);
  localparam route_t LIMIT = ROUTE_W'(NUM_OUTS);

  logic [VEC_W-1:0] level_d, level_q;
  logic [NUM_LINES-1:0][NUM_OUTS-1:0] col;

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
      assign level_d[o*NUM_LINES + p] = line_in[p] && (routes[p] < LIMIT)
                                        && (routes[p][OUT_W-1:0] == OUT_W'(o));
      assign col[p][o] = level_q[o*NUM_LINES + p];
    end
    assign irq_out[o] = |level_q[o*NUM_LINES +: NUM_LINES];
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  for (genvar p = 0; p < NUM_LINES; p++) begin : g_chk
    // R4: one line never reaches two outputs
    assert_single_target_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[p]));
    // R5: a low or parked line leaves no trace in the matrix
    assert_parked_silent_R5: assert property (@(posedge clk) disable iff (rst)
      (!line_in[p] || routes[p] >= LIMIT) |=> (col[p] == '0));
  end

  // R6: with every line low, all outputs fall on the next edge
  assert_all_low_R6: assert property (@(posedge clk) disable iff (rst)
    (line_in == '0) |=> (irq_out == '0));
endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query
  import pirq_steer_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes,
  input  logic [$clog2(NUM_LINES)-1:0] pin,
  output logic en,
  output logic [$clog2(NUM_OUTS):0] num
);
  localparam int OUT_W = $clog2(NUM_OUTS);
  localparam route_t LIMIT = ROUTE_W'(NUM_OUTS);

  route_t sel;
  assign sel = routes[pin];

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      num <= '1;
    end else if (sel < LIMIT) begin
      en  <= 1'b1;
      num <= {1'b0, sel[OUT_W-1:0]};
    end else begin
      en  <= 1'b0;
      num <= '1;
    end
  end

  // R8: a parked pin is reported as disabled with the invalid code
  assert_query_parked_R8: assert property (@(posedge clk) disable iff (rst)
    (routes[pin] >= LIMIT) |=> (!en && num == '1));
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
  parameter int LINE_W = 2,
  parameter int DEV_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic [DEV_W-1:0] dev,
  input  logic [LINE_W-1:0] pin,
  output logic [LINE_W-1:0] line
);
  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= pin + dev[LINE_W-1:0] - LINE_W'(1);
  end

  // R9: device 1 (mod 4) leaves the pin index unchanged
  assert_swizzle_identity_R9: assert property (@(posedge clk) disable iff (rst)
    (dev[LINE_W-1:0] == LINE_W'(1)) |=> (line == $past(pin)));
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_steer_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60,
  parameter int DEV_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ROUTE_W-1:0] cfg_wdata,
  output logic [ROUTE_W-1:0] cfg_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_OUTS-1:0] irq_out,
  input  logic [$clog2(NUM_LINES)-1:0] qry_pin,
  output logic qry_en,
  output logic [$clog2(NUM_OUTS):0] qry_num,
  input  logic [DEV_W-1:0] swz_dev,
  input  logic [$clog2(NUM_LINES)-1:0] swz_pin,
  output logic [$clog2(NUM_LINES)-1:0] swz_line
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0][ROUTE_W-1:0] route_q, route_nx;

  pirq_route_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .BASE(ROUTE_BASE), .RESET_VAL(8'h80)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .route_q(route_q), .route_nx(route_nx), .rdata(cfg_rdata)
  );

  pirq_level_matrix #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_matrix (
    .clk(clk), .rst(rst), .line_in(line_in), .routes(route_nx), .irq_out(irq_out)
  );

  pirq_route_query #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_query (
    .clk(clk), .rst(rst), .routes(route_q), .pin(qry_pin),
    .en(qry_en), .num(qry_num)
  );

  pirq_swizzle #(.LINE_W(LINE_W), .DEV_W(DEV_W)) u_swz (
    .clk(clk), .rst(rst), .dev(swz_dev), .pin(swz_pin), .line(swz_line)
  );

  // R1: the first cycle out of reset shows no interrupt activity
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0 && !qry_en));
endmodule

// File: tb/pirq_steer_bench.sv
module pirq_steer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [3:0] line_in = '0;
  logic [15:0] irq_out;
  logic [1:0] qry_pin = '0;
  logic qry_en;
  logic [4:0] qry_num;
  logic [4:0] swz_dev = '0;
  logic [1:0] swz_pin = '0, swz_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] rt [4];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  pirq_steer u_pirq_steer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .line_in(line_in),
    .irq_out(irq_out), .qry_pin(qry_pin), .qry_en(qry_en), .qry_num(qry_num),
    .swz_dev(swz_dev), .swz_pin(swz_pin), .swz_line(swz_line)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a >= 8'h60 && a <= 8'h63) rt[a - 8'h60] = d;
    tick();
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] model_irq(input logic [3:0] lv);
    logic [15:0] e = '0;
    for (int p = 0; p < 4; p++)
      if (lv[p] && rt[p] < 8'd16) e[rt[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++) begin
      cfg_addr = 8'h60 + 8'(i);
      tick();
      chk(req, {24'h0, cfg_rdata}, {24'h0, rt[i]});
    end
  endtask

  task automatic check_query();
    for (int i = 0; i < 4; i++) begin
      qry_pin = 2'(i);
      tick();
      if (rt[i] < 8'd16) chk("R8 query en/num", {26'h0, qry_en, qry_num}, {26'h0, 1'b1, 1'b0, rt[i][3:0]});
      else               chk("R8 query en/num", {26'h0, qry_en, qry_num}, {26'h0, 1'b0, 5'h1F});
    end
  endtask

  task automatic sweep_lines(input string req);
    for (int v = 0; v < 16; v++) begin
      line_in = 4'(v);
      tick();
      chk(req, {16'h0, irq_out}, {16'h0, model_irq(4'(v))});
    end
    line_in = '0;
    tick();
  endtask

  function automatic logic [7:0] pick_route(input logic [31:0] r);
    case (r[7:5])
      3'd0: return 8'h80 | {3'b0, r[12:8]};
      3'd1: return 8'h10 + {4'h0, r[11:8]};
      default: return {4'h0, r[11:8]};
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) rt[i] = 8'h80;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 irq_out at reset", {16'h0, irq_out}, 32'h0);
    check_regs("R1 reset route value");
    qry_pin = 2'd2;
    tick();
    chk("R1 query after reset", {26'h0, qry_en, qry_num}, {26'h0, 1'b0, 5'h1F});
    sweep_lines("R5 lines parked at reset");

    // R4/R6: directed routings, distinct, shared and boundary
    wr(8'h60, 8'd0); wr(8'h61, 8'd5); wr(8'h62, 8'd10); wr(8'h63, 8'd15);
    check_regs("R2 readback distinct");
    check_query();
    sweep_lines("R4 distinct targets");
    wr(8'h60, 8'd7); wr(8'h61, 8'd7); wr(8'h62, 8'd7); wr(8'h63, 8'd7);
    sweep_lines("R6 shared target");
    wr(8'h61, 8'h10); wr(8'h62, 8'hFF);
    check_query();
    sweep_lines("R5 boundary 16 and 0xFF parked");

    // R2/R4/R5/R6/R8: pseudo-random routing sets
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < 4; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        wr(8'h60 + 8'(i), pick_route(seed));
      end
      check_regs("R2 readback");
      check_query();
      sweep_lines("R6 merged outputs");
    end

    // R7: rewrite while line held high
    wr(8'h60, 8'd3); wr(8'h61, 8'h80); wr(8'h62, 8'h80); wr(8'h63, 8'h80);
    line_in = 4'b0001;
    tick();
    chk("R7 before rewrite", {16'h0, irq_out}, 32'h0008);
    wr(8'h60, 8'd9);
    chk("R7 moved at write edge", {16'h0, irq_out}, 32'h0200);
    wr(8'h60, 8'h80);
    chk("R7 parked at write edge", {16'h0, irq_out}, 32'h0);
    wr(8'h60, 8'd12);
    chk("R7 re-enabled at write edge", {16'h0, irq_out}, 32'h1000);

    // R3: stray writes ignored
    foreach (rt[i]) ;
    wr(8'h5F, 8'h01); wr(8'h64, 8'h02); wr(8'h00, 8'h03); wr(8'hFF, 8'h04);
    chk("R3 irq unchanged", {16'h0, irq_out}, 32'h1000);
    check_regs("R3 registers unchanged");
    cfg_addr = 8'h64;
    tick();
    chk("R2 read outside window", {24'h0, cfg_rdata}, 32'h0);
    cfg_addr = 8'h5F;
    tick();
    chk("R2 read below window", {24'h0, cfg_rdata}, 32'h0);
    line_in = '0;
    tick();

    // R9: swizzle exhaustive
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 4; p++) begin
        swz_dev = 5'(d); swz_pin = 2'(p);
        tick();
        chk("R9 swizzle", {30'h0, swz_line}, 32'((p + d + 3) % 4));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule